// File: doc/BRIEF.md
# Response Ring Codec Dispatcher

This block sits on the receive side of a codec command link. Each arriving response is a 64-bit entry: a 32-bit response word and a 32-bit extended word. When response traffic is enabled, every entry is written into a ring of power-of-two depth (256 entries by default). The entry is then classified from its extended word as solicited, unsolicited or spurious. Solicited responses are matched against per-codec counters of commands that have not yet been answered. These counters count up on a command-issue strobe, which carries the 32-bit command word.

Results leave the block on several outputs. Solicited data goes to a per-codec last-response register. Unsolicited entries go to a one-cycle event stream. Unmatched or badly addressed entries raise a one-cycle error pulse. Entries are also counted toward a programmable interrupt threshold. A pending counter that is already at its maximum raises an overflow pulse when another command arrives. A per-codec idle vector shows which codecs have nothing outstanding. All registered effects of an input appear after the clock edge that samples it.

Top module: `resp_ring_dispatch`

## Requirements
- R1: An accepted response (`rsp_valid` high while `cfg_dma_en` is high) sets `ring_we` for one cycle after the sampling edge. `ring_data` then holds the response word in bits 31:0 and the extended word in bits 63:32, so the response word sits at the even 32-bit word index and the extended word at the odd one. The entry index is `ring_wp`, and its byte offset is `ring_wp*8`.
- R2: `ring_wp` resets to 0. Each accepted response first advances it by one, modulo the ring depth, and then writes at the new value, so the first entry lands at index 1. A `wp_clear` pulse returns the pointer to 0. If a response is accepted in the same cycle, it is written at index 1.
- R3: A response with extended bit 4 set and an in-range address is reported on `evt_valid`/`evt_resp`/`evt_ext` and leaves every pending counter and last-response register unchanged.
- R4: A response whose extended bits 3:0 give an address at or above NUM_CODECS pulses `spur_err` and has no other effect besides the ring write, even if bit 4 is set.
- R5: A solicited response (bit 4 clear, address in range) for a codec whose pending count is nonzero stores the response word in that codec's slice of `last_resp` (bits 32*c+31:32*c) and decrements the count.
- R6: A solicited response for a codec whose pending count is zero pulses `spur_err` and leaves `last_resp` unchanged. The count used is the one held before the edge, so a command in the same cycle does not rescue it.
- R7: `cmd_valid` increments the pending count of the codec in command bits 31:28. An address at or above NUM_CODECS counts against codec 0. A command and a matching response for the same codec in one cycle leave the count unchanged.
- R8: A command for a codec whose count is at its maximum (2^PEND_W-1), with no decrement in the same cycle, keeps the count at the maximum and pulses `pend_ovf` one cycle later.
- R9: `codec_idle[c]` is high exactly when codec c has a pending count of zero.
- R10: Each accepted response adds one to an entry counter. When the counter reaches `cfg_irq_count` (0 behaves as 1), the counter restarts and a sticky interrupt flag is set. `irq_ack` clears the flag, but a new setting in the same cycle wins. `irq` is the flag ANDed with `cfg_irq_en`.
- R11: While `cfg_dma_en` is low, a response is ignored. There is no ring write, no pointer step, no event, no error, no counter change and no interrupt count.
- R12: After reset, all pulses are low, all counts are zero (so `codec_idle` is all ones), all last-response registers are zero, and the interrupt flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dma_en | input | 1 | Accept responses into the ring |
| cfg_irq_en | input | 1 | Gate for the interrupt output |
| cfg_irq_count | input | ICNT_W | Responses per interrupt (0 acts as 1) |
| irq_ack | input | 1 | Clears the interrupt flag |
| wp_clear | input | 1 | Returns the ring write pointer to 0 |
| cmd_valid | input | 1 | Command issued this cycle |
| cmd_word | input | 32 | Issued command; bits 31:28 give the codec |
| rsp_valid | input | 1 | Response entry present |
| rsp_word | input | 32 | Response word |
| rsp_ext | input | 32 | Extended word; bits 3:0 codec, bit 4 unsolicited |
| ring_we | output | 1 | Ring entry write strobe |
| ring_wp | output | RING_AW | Ring write pointer / index of the written entry |
| ring_data | output | 64 | Entry: extended word high, response word low |
| evt_valid | output | 1 | Unsolicited event strobe |
| evt_resp | output | 32 | Event response word |
| evt_ext | output | 32 | Event extended word |
| spur_err | output | 1 | Spurious or out-of-range response pulse |
| pend_ovf | output | 1 | Pending counter saturation pulse |
| codec_idle | output | NUM_CODECS | Per-codec no-outstanding-command flag |
| last_resp | output | 32*NUM_CODECS | Per-codec last solicited response |
| irq | output | 1 | Response interrupt |

## Verification
The bench builds the block with NUM_CODECS = 12 and PEND_W = 2 and keeps the default ring depth of 256. With twelve codecs, extended-word addresses 12 to 15 exercise the out-of-range error path. They also push command addresses above the limit onto codec 0. A two-bit pending counter saturates after three commands, so overflow and the same-cycle issue-and-match case occur many times in a short run. The default ring depth lets a burst of a little over 256 responses cover the pointer wrap.

// File: rtl/rrd_pkg.sv
`timescale 1ns/1ps
// Shared types and field positions for the response ring dispatcher.
// Assumes 32-bit command and extended words with a 4-bit codec field.
package rrd_pkg;
    localparam int EXT_ADDR_LSB  = 0;
    localparam int EXT_UNSOL_BIT = 4;
    localparam int CMD_ADDR_LSB  = 28;
    localparam int ADDR_W        = 4;

    typedef enum logic [1:0] {
        RSP_NONE      = 2'd0,
        RSP_SOLICITED = 2'd1,
        RSP_UNSOL     = 2'd2,
        RSP_SPURIOUS  = 2'd3
    } rsp_class_e;
endpackage

// File: rtl/rrd_classify.sv
`timescale 1ns/1ps
// Combinational sorter: decides the class of an accepted response from its
// extended word and the idle state of the addressed codec's counter.
// Assumes NUM_CODECS <= 16 (the address field is four bits).
module rrd_classify #(
    parameter int NUM_CODECS = 16
) (
    input  logic                   valid,
    input  logic [31:0]            ext,
    input  logic [NUM_CODECS-1:0]  codec_idle,
    output rrd_pkg::rsp_class_e    cls,
    output logic [NUM_CODECS-1:0]  dec_vec
);
    import rrd_pkg::*;

    logic [ADDR_W-1:0]     addr;
    logic                  in_range;
    logic                  busy;
    logic [NUM_CODECS-1:0] sel;

    assign addr     = ext[EXT_ADDR_LSB +: ADDR_W];
    assign in_range = (int'(addr) < NUM_CODECS);

    // Select the addressed codec and fetch whether it has commands outstanding.
    always_comb begin
        sel  = '0;
        busy = 1'b0;
        for (int i = 0; i < NUM_CODECS; i++) begin
            if (int'(addr) == i) begin
                sel[i] = 1'b1;
                busy   = ~codec_idle[i];
            end
        end
    end

    // Priority: range error, then unsolicited, then match or spurious.
    always_comb begin
        if (!valid)                  cls = RSP_NONE;
        else if (!in_range)          cls = RSP_SPURIOUS;
        else if (ext[EXT_UNSOL_BIT]) cls = RSP_UNSOL;
        else if (busy)               cls = RSP_SOLICITED;
        else                         cls = RSP_SPURIOUS;
    end

    assign dec_vec = (cls == RSP_SOLICITED) ? sel : '0;
endmodule

// File: rtl/rrd_pend_bank.sv
`timescale 1ns/1ps
// Per-codec bank of saturating outstanding-command counters and
// last-response registers. Commands decode their codec from bits 31:28;
// out-of-range addresses fold onto codec 0.
module rrd_pend_bank #(
    parameter int NUM_CODECS = 16,
    parameter int PEND_W     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [31:0]              cmd_word,
    input  logic [NUM_CODECS-1:0]    dec_vec,
    input  logic [31:0]              rsp_word,
    output logic [NUM_CODECS-1:0]    codec_idle,
    output logic [32*NUM_CODECS-1:0] last_resp,
    output logic                     pend_ovf
);
    import rrd_pkg::*;

    localparam logic [PEND_W-1:0] CNT_MAX = '1;

    logic [ADDR_W-1:0]     cmd_addr;
    logic [NUM_CODECS-1:0] inc_vec;
    logic [NUM_CODECS-1:0] sat_hit;

    assign cmd_addr = cmd_word[CMD_ADDR_LSB +: ADDR_W];

    // Decode the issuing codec, folding unsupported addresses to codec 0.
    always_comb begin
        for (int i = 0; i < NUM_CODECS; i++) begin
            inc_vec[i] = cmd_valid &&
                         ((int'(cmd_addr) == i) ||
                          (i == 0 && int'(cmd_addr) >= NUM_CODECS));
        end
    end

    for (genvar c = 0; c < NUM_CODECS; c++) begin : g_codec
        logic [PEND_W-1:0] cnt;
        logic [31:0]       last;

        // Count commands up and matched responses down, holding at maximum.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (inc_vec[c] && !dec_vec[c]) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else if (dec_vec[c] && !inc_vec[c]) begin
                cnt <= cnt - 1'b1;
            end
        end

        // Capture the response word of each matched solicited response.
        always_ff @(posedge clk) begin
            if (!rst_n)          last <= '0;
            else if (dec_vec[c]) last <= rsp_word;
        end

        assign sat_hit[c]             = inc_vec[c] && !dec_vec[c] && (cnt == CNT_MAX);
        assign codec_idle[c]          = (cnt == '0);
        assign last_resp[32*c +: 32]  = last;
    end

    // Register the saturation indication as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_ovf <= 1'b0;
        else        pend_ovf <= |sat_hit;
    end
endmodule

// File: rtl/rrd_ring_ptr.sv
`timescale 1ns/1ps
// Ring write pointer: optional clear to 0, then pre-increment per write.
// Assumes DEPTH is a power of two so the wrap is the natural overflow.
module rrd_ring_ptr #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          clr,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] base;

    assign base = clr ? '0 : ptr;

    // Advance the pointer for each accepted entry, after any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)  ptr <= '0;
        else if (we) ptr <= base + 1'b1;
        else         ptr <= base;
    end
endmodule

// File: rtl/rrd_irq_ctr.sv
`timescale 1ns/1ps
// Response interrupt: counts accepted entries up to a programmed threshold
// (0 treated as 1), then sets a sticky flag cleared by acknowledge.
module rrd_irq_ctr #(
    parameter int ICNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ICNT_W-1:0] thr_cfg,
    input  logic              ack,
    input  logic              en,
    output logic              irq
);
    logic [ICNT_W-1:0] cnt;
    logic [ICNT_W-1:0] thr;
    logic [ICNT_W:0]   step;
    logic              reach;
    logic              flag;

    assign thr   = (thr_cfg == '0) ? ICNT_W'(1) : thr_cfg;
    assign step  = {1'b0, cnt} + 1'b1;
    assign reach = hit && (step >= {1'b0, thr});

    // Track entries since the last interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (reach) cnt <= '0;
        else if (hit)   cnt <= step[ICNT_W-1:0];
    end

    // Hold the interrupt until acknowledged; a new setting beats the ack.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (reach) flag <= 1'b1;
        else if (ack)   flag <= 1'b0;
    end

    assign irq = flag && en;
endmodule

// File: rtl/resp_ring_dispatch.sv
`timescale 1ns/1ps
// Top: accepts 64-bit response entries, writes them to the ring interface,
// sorts them into solicited / unsolicited / spurious, and drives the per-codec
// bookkeeping and the response interrupt. All effects land one edge later.
module resp_ring_dispatch #(
    parameter int NUM_CODECS = 16,
    parameter int PEND_W     = 4,
    parameter int RING_DEPTH = 256,
    parameter int ICNT_W     = 8,
    localparam int RING_AW   = $clog2(RING_DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_dma_en,
    input  logic                     cfg_irq_en,
    input  logic [ICNT_W-1:0]        cfg_irq_count,
    input  logic                     irq_ack,
    input  logic                     wp_clear,
    input  logic                     cmd_valid,
    input  logic [31:0]              cmd_word,
    input  logic                     rsp_valid,
    input  logic [31:0]              rsp_word,
    input  logic [31:0]              rsp_ext,
    output logic                     ring_we,
    output logic [RING_AW-1:0]       ring_wp,
    output logic [63:0]              ring_data,
    output logic                     evt_valid,
    output logic [31:0]              evt_resp,
    output logic [31:0]              evt_ext,
    output logic                     spur_err,
    output logic                     pend_ovf,
    output logic [NUM_CODECS-1:0]    codec_idle,
    output logic [32*NUM_CODECS-1:0] last_resp,
    output logic                     irq
);
    import rrd_pkg::*;

    logic                  accept;
    rsp_class_e            cls;
    logic [NUM_CODECS-1:0] dec_vec;

    assign accept = rsp_valid && cfg_dma_en;

    rrd_classify #(.NUM_CODECS(NUM_CODECS)) u_cls (
        .valid      (accept),
        .ext        (rsp_ext),
        .codec_idle (codec_idle),
        .cls        (cls),
        .dec_vec    (dec_vec)
    );

    rrd_pend_bank #(.NUM_CODECS(NUM_CODECS), .PEND_W(PEND_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .dec_vec    (dec_vec),
        .rsp_word   (rsp_word),
        .codec_idle (codec_idle),
        .last_resp  (last_resp),
        .pend_ovf   (pend_ovf)
    );

    rrd_ring_ptr #(.DEPTH(RING_DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept),
        .clr   (wp_clear),
        .ptr   (ring_wp)
    );

    rrd_irq_ctr #(.ICNT_W(ICNT_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (accept),
        .thr_cfg (cfg_irq_count),
        .ack     (irq_ack),
        .en      (cfg_irq_en),
        .irq     (irq)
    );

    // Register the ring write strobe and strobes derived from the class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_we   <= 1'b0;
            evt_valid <= 1'b0;
            spur_err  <= 1'b0;
        end else begin
            ring_we   <= accept;
            evt_valid <= (cls == RSP_UNSOL);
            spur_err  <= (cls == RSP_SPURIOUS);
        end
    end

    // Register the entry payload and event payload alongside their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_data <= '0;
            evt_resp  <= '0;
            evt_ext   <= '0;
        end else if (accept) begin
            ring_data <= {rsp_ext, rsp_word};
            evt_resp  <= rsp_word;
            evt_ext   <= rsp_ext;
        end
    end
endmodule

// File: rtl/resp_ring_dispatch_chk.sv
`timescale 1ns/1ps
// Property checker for resp_ring_dispatch, attached by bind below.
module resp_ring_dispatch_chk #(
    parameter int NUM_CODECS = 16,
    parameter int RING_AW    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_dma_en,
    input logic                  cfg_irq_en,
    input logic                  wp_clear,
    input logic                  cmd_valid,
    input logic                  rsp_valid,
    input logic                  ring_we,
    input logic [RING_AW-1:0]    ring_wp,
    input logic                  evt_valid,
    input logic                  spur_err,
    input logic                  pend_ovf,
    input logic [NUM_CODECS-1:0] codec_idle,
    input logic                  irq
);
    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_valid, spur_err}));

    assert_evt_written_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ring_we);

    assert_dma_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |=> !ring_we);

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cfg_dma_en && !wp_clear) |=>
            (ring_wp == RING_AW'($past(ring_wp) + 1'b1)));

    assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_clear && !(rsp_valid && cfg_dma_en)) |=> (ring_wp == '0));

    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_ovf |-> $past(cmd_valid));

    assert_cmd_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !(&codec_idle));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_irq_en);
endmodule

bind resp_ring_dispatch resp_ring_dispatch_chk #(
    .NUM_CODECS (NUM_CODECS),
    .RING_AW    (RING_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_dma_en (cfg_dma_en),
    .cfg_irq_en (cfg_irq_en),
    .wp_clear   (wp_clear),
    .cmd_valid  (cmd_valid),
    .rsp_valid  (rsp_valid),
    .ring_we    (ring_we),
    .ring_wp    (ring_wp),
    .evt_valid  (evt_valid),
    .spur_err   (spur_err),
    .pend_ovf   (pend_ovf),
    .codec_idle (codec_idle),
    .irq        (irq)
);

// File: tb/sim_resp_ring_dispatch.sv
`timescale 1ns/1ps
module sim_resp_ring_dispatch;
    localparam int NC   = 12;
    localparam int PW   = 2;
    localparam int PMAX = 3;
    localparam int ICW  = 8;
    localparam int AW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dma_en = 1'b0, cfg_irq_en = 1'b0, irq_ack = 1'b0, wp_clear = 1'b0;
    logic [ICW-1:0] cfg_irq_count = '0;
    logic cmd_valid = 1'b0, rsp_valid = 1'b0;
    logic [31:0] cmd_word = '0, rsp_word = '0, rsp_ext = '0;
    logic ring_we, evt_valid, spur_err, pend_ovf, irq;
    logic [AW-1:0] ring_wp;
    logic [63:0] ring_data;
    logic [31:0] evt_resp, evt_ext;
    logic [NC-1:0] codec_idle;
    logic [32*NC-1:0] last_resp;

    always #4 clk = ~clk;

    resp_ring_dispatch #(.NUM_CODECS(NC), .PEND_W(PW), .RING_DEPTH(256), .ICNT_W(ICW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_irq_en(cfg_irq_en),
        .cfg_irq_count(cfg_irq_count), .irq_ack(irq_ack), .wp_clear(wp_clear),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .rsp_valid(rsp_valid),
        .rsp_word(rsp_word), .rsp_ext(rsp_ext), .ring_we(ring_we), .ring_wp(ring_wp),
        .ring_data(ring_data), .evt_valid(evt_valid), .evt_resp(evt_resp),
        .evt_ext(evt_ext), .spur_err(spur_err), .pend_ovf(pend_ovf),
        .codec_idle(codec_idle), .last_resp(last_resp), .irq(irq));

    int n_run = 0, n_fail = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int          m_pend[NC];
    logic [31:0] m_last[NC];
    int          m_ptr, m_icnt;
    bit          m_flag, e_we, e_evt, e_spur, e_ovf;
    logic [63:0] e_data;
    logic [31:0] e_er, e_ex;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_pend[i]) begin m_pend[i] = 0; m_last[i] = '0; end
            m_ptr = 0; m_icnt = 0; m_flag = 0;
            e_we = 0; e_evt = 0; e_spur = 0; e_ovf = 0; e_data = '0; e_er = '0; e_ex = '0;
        end else begin
            automatic bit acc = rsp_valid && cfg_dma_en;
            automatic int ra = int'(rsp_ext[3:0]);
            automatic int ca = int'(cmd_word[31:28]);
            automatic bit dec = 0;
            automatic int thr = (cfg_irq_count == 0) ? 1 : int'(cfg_irq_count);
            automatic bit reach = 0;
            e_evt = 0; e_spur = 0; e_ovf = 0;
            if (wp_clear) m_ptr = 0;
            e_we = acc;
            if (acc) begin
                m_ptr = (m_ptr + 1) % 256;
                e_data = {rsp_ext, rsp_word}; e_er = rsp_word; e_ex = rsp_ext;
                if (ra >= NC) e_spur = 1;
                else if (rsp_ext[4]) e_evt = 1;
                else if (m_pend[ra] > 0) begin
                    dec = 1; m_pend[ra]--; m_last[ra] = rsp_word;
                end else e_spur = 1;
                m_icnt++;
                if (m_icnt >= thr) begin m_icnt = 0; reach = 1; end
            end
            if (cmd_valid) begin
                if (ca >= NC) ca = 0;
                if (dec && ra == ca) m_pend[ca]++;
                else if (m_pend[ca] == PMAX) e_ovf = 1;
                else m_pend[ca]++;
            end
            if (irq_ack) m_flag = 0;
            if (reach) m_flag = 1;
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(ring_we === e_we, "R1", "ring_we", 64'(ring_we), 64'(e_we));
            if (e_we) chk(ring_data === e_data, "R1", "ring_data", ring_data, e_data);
            chk(int'(ring_wp) == m_ptr, "R2", "ring_wp", 64'(ring_wp), 64'(m_ptr));
            chk(evt_valid === e_evt, "R3", "evt_valid", 64'(evt_valid), 64'(e_evt));
            if (e_evt) chk({evt_ext, evt_resp} === {e_ex, e_er}, "R3", "evt payload",
                           {evt_ext, evt_resp}, {e_ex, e_er});
            chk(spur_err === e_spur, "R6", "spur_err", 64'(spur_err), 64'(e_spur));
            chk(pend_ovf === e_ovf, "R8", "pend_ovf", 64'(pend_ovf), 64'(e_ovf));
            for (int i = 0; i < NC; i++) begin
                chk(codec_idle[i] === (m_pend[i] == 0), "R9", "codec_idle",
                    64'(codec_idle[i]), 64'(m_pend[i] == 0));
                chk(last_resp[32*i +: 32] === m_last[i], "R5", "last_resp",
                    64'(last_resp[32*i +: 32]), 64'(m_last[i]));
            end
            chk(irq === (m_flag && cfg_irq_en), "R10", "irq", 64'(irq), 64'(m_flag && cfg_irq_en));
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic clr_in();
        cmd_valid = 0; rsp_valid = 0; wp_clear = 0; irq_ack = 0;
    endtask

    task automatic cmd(input logic [3:0] a);
        cmd_valid = 1; cmd_word = {a, 28'h00A5F0F}; cyc(); clr_in();
    endtask

    task automatic rsp(input logic [31:0] w, input bit uns, input logic [3:0] a);
        rsp_valid = 1; rsp_word = w; rsp_ext = {27'h0, uns, a}; cyc(); clr_in();
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1; cmp_on = 1;
        @(negedge clk);
        // R12: reset state
        chk(codec_idle === '1, "R12", "idle after reset", 64'(codec_idle), 64'('1));
        chk(ring_wp === '0, "R12", "ring_wp after reset", 64'(ring_wp), 64'd0);
        chk(!irq && !spur_err && !pend_ovf && !ring_we, "R12", "pulses after reset", 64'(irq), 64'd0);
        #2;
        cfg_dma_en = 1; cfg_irq_en = 1; cfg_irq_count = 8'd1;

        // R5: matched solicited response
        cmd(4'd3);
        rsp(32'hCAFE0003, 0, 4'd3);
        chk(last_resp[96 +: 32] === 32'hCAFE0003, "R5", "codec3 last", 64'(last_resp[96 +: 32]), 64'hCAFE0003);
        chk(codec_idle[3] === 1'b1, "R9", "codec3 idle", 64'(codec_idle[3]), 64'd1);
        // R6: unmatched solicited response
        rsp(32'h11110003, 0, 4'd3);
        chk(spur_err === 1'b1, "R6", "spurious pulse", 64'(spur_err), 64'd1);
        chk(last_resp[96 +: 32] === 32'hCAFE0003, "R6", "codec3 kept", 64'(last_resp[96 +: 32]), 64'hCAFE0003);
        // R3: unsolicited with a pending command does not consume it
        cmd(4'd5);
        rsp(32'hEEEE0005, 1, 4'd5);
        chk(evt_valid === 1'b1 && evt_resp === 32'hEEEE0005, "R3", "event", 64'(evt_resp), 64'hEEEE0005);
        chk(codec_idle[5] === 1'b0, "R3", "codec5 still pending", 64'(codec_idle[5]), 64'd0);
        rsp(32'h55550005, 0, 4'd5);
        // R4: out-of-range addresses, solicited and unsolicited
        rsp(32'hBAD0000D, 0, 4'd13);
        chk(spur_err === 1'b1, "R4", "range error", 64'(spur_err), 64'd1);
        rsp(32'hBAD0000E, 1, 4'd14);
        chk(spur_err === 1'b1 && evt_valid === 1'b0, "R4", "range beats unsol", 64'(evt_valid), 64'd0);
        // R7: command to codec 15 folds onto codec 0
        cmd(4'd15);
        chk(codec_idle[0] === 1'b0, "R7", "fold to codec0", 64'(codec_idle[0]), 64'd0);
        rsp(32'h0000F00D, 0, 4'd0);
        chk(last_resp[0 +: 32] === 32'h0000F00D, "R7", "codec0 last", 64'(last_resp[0 +: 32]), 64'h0000F00D);
        // R8: saturation at 3
        cmd(4'd2); cmd(4'd2); cmd(4'd2); cmd(4'd2);
        chk(pend_ovf === 1'b1, "R8", "overflow pulse", 64'(pend_ovf), 64'd1);
        // R7: same-cycle command and match for codec 2
        cmd_valid = 1; cmd_word = {4'd2, 28'h0}; rsp_valid = 1; rsp_word = 32'h22222222;
        rsp_ext = 32'd2; cyc(); clr_in();
        chk(pend_ovf === 1'b0, "R7", "no overflow on net zero", 64'(pend_ovf), 64'd0);
        rsp(32'h2, 0, 4'd2); rsp(32'h3, 0, 4'd2); rsp(32'h4, 0, 4'd2);
        chk(codec_idle[2] === 1'b1, "R8", "drained at max", 64'(codec_idle[2]), 64'd1);
        // R6: command and response in the same cycle on an idle codec
        cmd_valid = 1; cmd_word = {4'd7, 28'h0}; rsp_valid = 1; rsp_word = 32'h7; rsp_ext = 32'd7;
        cyc(); clr_in();
        chk(spur_err === 1'b1 && codec_idle[7] === 1'b0, "R6", "same-cycle no rescue", 64'(spur_err), 64'd1);
        rsp(32'h77, 0, 4'd7);
        // R11: DMA disabled ignores responses
        cfg_dma_en = 0;
        cmd(4'd9);
        rsp(32'h99, 0, 4'd9);
        chk(ring_we === 1'b0 && codec_idle[9] === 1'b0, "R11", "ignored response", 64'(ring_we), 64'd0);
        cfg_dma_en = 1;
        rsp(32'h999, 0, 4'd9);
        // R10: threshold 3 with acknowledge
        irq_ack = 1; cyc(); clr_in();
        cfg_irq_count = 8'd3;
        rsp(32'h1, 1, 4'd1); rsp(32'h2, 1, 4'd1);
        chk(irq === 1'b0, "R10", "below threshold", 64'(irq), 64'd0);
        rsp(32'h3, 1, 4'd1);
        chk(irq === 1'b1, "R10", "at threshold", 64'(irq), 64'd1);
        cfg_irq_en = 0; cyc();
        chk(irq === 1'b0, "R10", "gated", 64'(irq), 64'd0);
        cfg_irq_en = 1; irq_ack = 1; cyc(); clr_in();
        chk(irq === 1'b0, "R10", "acked", 64'(irq), 64'd0);
        // R2: clear then wrap
        wp_clear = 1; cyc(); clr_in();
        chk(ring_wp === 8'd0, "R2", "cleared", 64'(ring_wp), 64'd0);
        for (int k = 0; k < 260; k++) begin
            rsp_valid = 1; rsp_word = 32'(k); rsp_ext = 32'h10 | 32'(k % 12); cyc();
        end
        clr_in();
        chk(ring_wp === 8'd4, "R2", "wrapped", 64'(ring_wp), 64'd4);
        wp_clear = 1; rsp_valid = 1; rsp_word = 32'hAB; rsp_ext = 32'h11; cyc(); clr_in();
        chk(ring_wp === 8'd1 && ring_data === {32'h11, 32'hAB}, "R1", "clear with write", 64'(ring_wp), 64'd1);
        // Mixed traffic against the model
        for (int k = 0; k < 4000; k++) begin
            cmd_valid = ($urandom_range(0, 2) == 0);
            cmd_word = {4'($urandom_range(0, 15)), 28'($urandom)};
            rsp_valid = ($urandom_range(0, 1) == 0);
            rsp_word = $urandom;
            rsp_ext = {27'h0, ($urandom_range(0, 3) == 0), 4'($urandom_range(0, 15))};
            cfg_dma_en = ($urandom_range(0, 7) != 0);
            cfg_irq_en = ($urandom_range(0, 3) != 0);
            wp_clear = ($urandom_range(0, 63) == 0);
            irq_ack = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 99) == 0) cfg_irq_count = 8'($urandom_range(0, 5));
            cyc();
        end
        clr_in();
        repeat (2) cyc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule